// File: doc/BRIEF.md
# Lowest-Zero Position Encoder

This block scans a wide status vector, 1024 bits by default, and reports two things: whether any bit is clear, and the binary index of the lowest clear bit. A typical use is slot allocation. A bit at 1 marks a slot as taken. The encoder finds the free slot with the smallest index, so a separate agent can claim it. The encoder never changes the vector.

The search is a tree with a fan-in of four. Each leaf looks at four neighbouring bits. It reports a hit flag and the 2-bit offset of the first clear bit among them. Every higher level does the same job over four hit flags from the level below. It then uses its own 2-bit offset to steer a 4:1 multiplexer, which picks the partial index of the chosen child. The partial index gains two bits at each level until the root holds the full position. A parameter selects whether the result is registered on the clock edge or passed straight through.

Top module: `fz_locator`

## Requirements
- R1: `zero_found_o` is 1 whenever at least one bit of the examined vector is 0.
- R2: When every bit of the examined vector is 1, `none_found_o` is 1, `zero_found_o` is 0 and `pos_o` is 0.
- R3: When a zero exists, `pos_o` is the smallest index i for which bit i of the vector is 0, where bit 0 is the least significant bit of `vec_i`.
- R4: `pos_o` is an unsigned binary number of log2(WIDTH) bits. It reaches both ends of its range: 0 when bit 0 is the only clear bit, and WIDTH-1 when only the top bit is clear.
- R5: With REG_OUT=1 the outputs reflect the vector present at the previous rising clock edge and hold until the next edge. With REG_OUT=0 they follow `vec_i` within the same cycle.
- R6: While `rst_n` is low with REG_OUT=1, the outputs read `zero_found_o`=0, `none_found_o`=1 and `pos_o`=0, whatever `vec_i` holds.
- R7: Clear bits above the lowest clear bit have no effect on `pos_o`.
- R8: WIDTH must be a power of four. The tree then has log4(WIDTH) levels, and level k holds WIDTH/4^(k+1) groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| vec_i | input | WIDTH | Status vector to be searched |
| zero_found_o | output | 1 | At least one bit is 0 |
| none_found_o | output | 1 | Every bit is 1 |
| pos_o | output | log2(WIDTH) | Index of the lowest 0 bit, or 0 when there is none |

## Verification
The bench aims at the corners where a tree encoder tends to go wrong:
- **Only bit 0 or only the top bit clear.** A multiplexer select that is wired backwards, or a level whose bits are swapped, shows up here as a mirrored or truncated position.
- **Two or more clear bits in different subtrees.** This tests priority. A level that prefers its upper child, or a wrong child feeding the steering multiplexer, reports the higher zero.
- **All ones and all zeros.** These test the flags and the forced-zero position.
- **Latency of the registered instance, checked just after a new vector is applied.** A missing or extra register stage shows the new result a cycle too early or too late.
- **A second, unregistered 64-bit instance.** This covers a shallower tree and the pass-through variant.

// File: rtl/fz_pkg.sv
package fz_pkg;

    // Offset of the first clear bit among four, lowest index first.
    function automatic logic [1:0] first_hit(input logic [3:0] hit);
        logic [1:0] r;
        r = 2'd0;
        if (hit[0])      r = 2'd0;
        else if (hit[1]) r = 2'd1;
        else if (hit[2]) r = 2'd2;
        else if (hit[3]) r = 2'd3;
        return r;
    endfunction

    // Start of level `lvl` inside the flat node storage.
    function automatic int level_base(input int width, input int lvl);
        int acc;
        acc = 0;
        for (int i = 0; i < lvl; i++) acc += width >> (2 * (i + 1));
        return acc;
    endfunction

endpackage

// File: rtl/fz_group4.sv
module fz_group4 (
    input  logic [3:0] hit_i,
    output logic       found_o,
    output logic [1:0] idx_o
);
    import fz_pkg::*;

    always_comb begin
        found_o = |hit_i;
        idx_o   = first_hit(hit_i);
    end
endmodule

// File: rtl/fz_mux4.sv
module fz_mux4 #(
    parameter int W = 2
) (
    input  logic [3:0][W-1:0] data_i,
    input  logic [1:0]        sel_i,
    output logic [W-1:0]      data_o
);
    always_comb data_o = data_i[sel_i];
endmodule

// File: rtl/fz_locator.sv
module fz_locator #(
    parameter int WIDTH   = 1024,
    parameter int REG_OUT = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WIDTH-1:0]         vec_i,
    output logic                     zero_found_o,
    output logic                     none_found_o,
    output logic [$clog2(WIDTH)-1:0] pos_o
);
    import fz_pkg::*;

    localparam int POS_W  = $clog2(WIDTH);
    localparam int LEVELS = POS_W / 2;
    localparam int TOTAL  = (WIDTH - 1) / 3;
    localparam int ROOT   = TOTAL - 1;

    // R8: reject widths that are not powers of four
    if ((1 << POS_W) != WIDTH || (POS_W % 2) != 0 || WIDTH < 4) begin : g_bad_width
        $error("fz_locator: WIDTH must be a power of four");
    end

    logic [TOTAL-1:0] node_found;
    logic [POS_W-1:0] node_pos [TOTAL];

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        localparam int NODES = WIDTH >> (2 * (lv + 1));
        localparam int BASE  = level_base(WIDTH, lv);
        localparam int CBASE = (lv == 0) ? 0 : level_base(WIDTH, lv - 1);
        localparam int PW    = 2 * (lv + 1);

        for (genvar j = 0; j < NODES; j++) begin : g_node
            logic [3:0] hit;
            logic [1:0] idx;

            if (lv == 0) begin : g_leaf
                assign hit = ~vec_i[4*j +: 4];
            end else begin : g_inner
                assign hit = node_found[CBASE + 4*j +: 4];
            end

            fz_group4 u_grp (
                .hit_i   (hit),
                .found_o (node_found[BASE + j]),
                .idx_o   (idx)
            );

            if (lv == 0) begin : g_leafpos
                if (POS_W > 2) begin : g_pad
                    assign node_pos[BASE + j] = {{(POS_W-2){1'b0}}, idx};
                end else begin : g_nopad
                    assign node_pos[BASE + j] = idx;
                end
            end else begin : g_steer
                logic [3:0][PW-3:0] kids;
                logic [PW-3:0]      sub;
                for (genvar k = 0; k < 4; k++) begin : g_kid
                    assign kids[k] = node_pos[CBASE + 4*j + k][PW-3:0];
                end
                fz_mux4 #(.W(PW-2)) u_mux (
                    .data_i (kids),
                    .sel_i  (idx),
                    .data_o (sub)
                );
                if (PW < POS_W) begin : g_pad
                    assign node_pos[BASE + j] = {{(POS_W-PW){1'b0}}, idx, sub};
                end else begin : g_nopad
                    assign node_pos[BASE + j] = {idx, sub};
                end
            end
        end
    end

    typedef struct packed {
        logic             found;
        logic [POS_W-1:0] pos;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d.found = node_found[ROOT];
        res_d.pos   = node_found[ROOT] ? node_pos[ROOT] : '0;
    end

    if (REG_OUT != 0) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign zero_found_o = res_q.found;
    assign none_found_o = ~res_q.found;
    assign pos_o        = res_q.pos;

endmodule

// File: rtl/fz_locator_chk.sv
module fz_locator_chk #(
    parameter int WIDTH   = 1024,
    parameter int REG_OUT = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [WIDTH-1:0]         vec_i,
    input logic                     zero_found_o,
    input logic                     none_found_o,
    input logic [$clog2(WIDTH)-1:0] pos_o
);
    logic [WIDTH-1:0] seen;
    logic [WIDTH-1:0] below;

    if (REG_OUT != 0) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) seen <= '1;
            else        seen <= vec_i;
        end
    end else begin : g_comb
        assign seen = vec_i;
    end

    always_comb below = ({{(WIDTH-1){1'b0}}, 1'b1} << pos_o) - 1'b1;

    AST_ZERO_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        !(&seen) |-> zero_found_o);                                                 // R1
    AST_ALL_ONES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (&seen) |-> (none_found_o && !zero_found_o && pos_o == '0));                // R2
    AST_POS_HITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        zero_found_o |-> !seen[pos_o]);                                             // R3
    AST_NOTHING_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        zero_found_o |-> ((seen & below) == below));                                // R7
endmodule

bind fz_locator fz_locator_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/fz_locator_bench.sv
module fz_locator_bench;
    localparam int W  = 1024;
    localparam int PW = 10;
    localparam int WC = 64;
    localparam int PC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  vec = '0;
    logic          zf, nf;
    logic [PW-1:0] pos;
    logic [WC-1:0] vec_c = '1;
    logic          zf_c, nf_c;
    logic [PC-1:0] pos_c;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    fz_locator #(.WIDTH(W), .REG_OUT(1)) u_fz_locator (
        .clk(clk), .rst_n(rst_n), .vec_i(vec),
        .zero_found_o(zf), .none_found_o(nf), .pos_o(pos));

    fz_locator #(.WIDTH(WC), .REG_OUT(0)) u_fz_locator_comb (
        .clk(clk), .rst_n(rst_n), .vec_i(vec_c),
        .zero_found_o(zf_c), .none_found_o(nf_c), .pos_o(pos_c));

    function automatic int ref_first(input logic [W-1:0] v, input int n);
        for (int i = 0; i < n; i++) if (!v[i]) return i;
        return -1;
    endfunction

    task automatic check(input string req, input logic f, input logic n,
                         input int p, input int exp);
        logic ef;
        int   ep;
        ef = (exp >= 0);
        ep = ef ? exp : 0;
        checks++;
        if (f !== ef || n !== !ef || p != ep) begin
            failures++;
            $display("FAIL %s: found=%0b none=%0b pos=%0d expected found=%0b none=%0b pos=%0d",
                     req, f, n, p, ef, !ef, ep);
        end
    endtask

    // Drive at a falling edge; registered result is valid at the next falling edge.
    task automatic apply(input string req, input logic [W-1:0] v);
        @(negedge clk);
        vec   = v;
        vec_c = v[WC-1:0];
        #1;
        check({req, " comb R5"}, zf_c, nf_c, int'(pos_c), ref_first(v, WC));
        @(negedge clk);
        check({req, " reg"}, zf, nf, int'(pos), ref_first(v, W));
    endtask

    function automatic logic [W-1:0] rand_vec();
        logic [W-1:0] v;
        for (int w = 0; w < W / 32; w++) v[32*w +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] a;
        logic [W-1:0] b;
        void'($urandom(32'd5150));

        // R6: reset dominates an all-zero vector
        repeat (3) @(negedge clk);
        check("R6 reset", zf, nf, int'(pos), -1);
        rst_n = 1'b1;

        apply("R2 all ones", '1);
        apply("R1 all zeros", '0);

        // R4 boundaries
        v = '1; v[0] = 1'b0;     apply("R4 only bit0", v);
        v = '1; v[W-1] = 1'b0;   apply("R4 only top bit", v);

        // R3 single zero across positions
        for (int i = 0; i < W; i += 37) begin
            v = '1; v[i] = 1'b0; apply("R3 single zero", v);
        end

        // R7 higher zeros ignored, zeros in different subtrees
        v = '1; v[700] = 1'b0; v[1023] = 1'b0; v[300] = 1'b0; apply("R7 three zeros", v);
        v = '1; v[16] = 1'b0; v[15] = 1'b0;    apply("R7 adjacent groups", v);
        v = '1; v[256] = 1'b0; v[1000] = 1'b0; apply("R7 subtree edge", v);
        v = '1; v[63] = 1'b0; v[64] = 1'b0;    apply("R7 comb top", v);

        // R5 latency of registered output
        a = '1; a[5] = 1'b0;
        b = '1; b[900] = 1'b0;
        apply("R5 setup", a);
        @(negedge clk);
        vec = b;
        #1;
        check("R5 holds old", zf, nf, int'(pos), 5);
        @(negedge clk);
        check("R5 new after edge", zf, nf, int'(pos), 900);

        // Random sparse zeros (R3, R7)
        for (int n = 0; n < 300; n++) begin
            v = '1;
            for (int k = 0; k < 1 + int'($urandom % 4); k++) v[$urandom % W] = 1'b0;
            apply("R3 random sparse", v);
        end
        // Random dense vectors (R1, R3)
        for (int n = 0; n < 100; n++) apply("R1 random dense", rand_vec());

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule